// File: doc/BRIEF.md
# Serial Port DMA Request Controller

This block connects the transmit and receive FIFOs of a synchronous serial port to a DMA engine. It reads the receive FIFO's fill level and the transmit FIFO's free-slot count. From these it drives a single-transfer request and a burst request for each direction. Each direction has its own enable. While an enable is clear, both requests for that direction are held low.

The block also holds three raw status flags:
- transmit DMA finished,
- receive DMA finished,
- end of transmission, meaning the transmit FIFO is empty and the shifter has sent its last bit.

A small synchronous register bus gives access to the control enables, raw status, interrupt mask, masked status and a write-one-to-clear register. An interrupt line is the OR of the masked flags. The transmit-finished flag has a guarded clearing rule: software must first drop the transmit enable, and only then can it clear the flag.

Top module: `spdma_ctrl`

## Requirements
- R1: The receive single request is high exactly when receive DMA is enabled and `rx_level` is at least 1.
- R2: The receive burst request is high exactly when receive DMA is enabled and `rx_level` is at least `BURST_LVL` (default 4).
- R3: The transmit single request is high exactly when transmit DMA is enabled and `tx_free` is at least 1.
- R4: The transmit burst request is high exactly when transmit DMA is enabled and `tx_free` is at least `BURST_LVL` (default 4).
- R5: The control register is at address 0, with bit 0 as the receive enable and bit 1 as the transmit enable. It reads back as written. When an enable is clear, both requests of that direction stay low for any FIFO level, and they resume once the enable is set again.
- R6: A one-cycle pulse on `tx_dma_done` sets raw status bit 0 (raw status is at address 1). The bit is visible on the clock edge that samples the pulse.
- R7: Writing 1 to bit 0 of the clear register (address 4) has no effect on raw bit 0 while the transmit enable is set. The same write clears raw bit 0 when the transmit enable is clear.
- R8: A pulse on `rx_dma_done` sets raw status bit 1. Writing 1 to bit 1 of the clear register clears raw bit 1 whatever the receive enable is.
- R9: Raw status bit 2 (end of transmission) is 1 one cycle after `tx_free` equals `FIFO_DEPTH` while `shifter_busy` is low, and 0 one cycle after either condition fails. Writes to the clear register do not affect it.
- R10: The mask register (address 2, bits 2:0) reads back as written. The masked status (address 3) equals raw AND mask. `irq` is high exactly when any masked bit is 1.
- R11: While `rst_n` is low, the control register, mask register, all raw status bits, all requests and `irq` are 0.
- R12: When a completion pulse and a clear write for the same bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rx_level | input | $clog2(FIFO_DEPTH+1) | Items held in the receive FIFO |
| tx_free | input | $clog2(FIFO_DEPTH+1) | Empty slots in the transmit FIFO |
| shifter_busy | input | 1 | Serializer is still sending a frame |
| tx_dma_done | input | 1 | DMA finished a transmit transfer (pulse) |
| rx_dma_done | input | 1 | DMA finished a receive transfer (pulse) |
| rx_req_single | output | 1 | Receive single-transfer request |
| rx_req_burst | output | 1 | Receive burst request |
| tx_req_single | output | 1 | Transmit single-transfer request |
| tx_req_burst | output | 1 | Transmit burst request |
| irq | output | 1 | OR of the masked status bits |

## Verification
The assertions assume that `rx_level` and `tx_free` never exceed `FIFO_DEPTH`. They also assume that the completion inputs are single-cycle pulses and that each bus write lasts one cycle. The directed stimulus only drives levels between 0 and the depth. It raises each done input for exactly one clock. It changes inputs only on the falling edge, so each rising edge samples a settled value. The bench samples combinational request outputs after they settle. It reads registered status one falling edge after the rising edge that updates it.

// File: rtl/spdma_pkg.sv
// Package: shared register addresses and bit positions for the serial DMA
// request controller. Assumes a 3-bit register address space.
package spdma_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_RAW   = 3'd1,
        REG_MASK  = 3'd2,
        REG_MSKD  = 3'd3,
        REG_CLR   = 3'd4
    } reg_addr_e;

    // Status bit positions (shared by raw, mask, masked and clear registers)
    localparam int ST_TXDONE = 0;
    localparam int ST_RXDONE = 1;
    localparam int ST_EOT    = 2;
    localparam int ST_W      = 3;

    // Control bit positions
    localparam int CTL_RXEN = 0;
    localparam int CTL_TXEN = 1;
    localparam int CTL_W    = 2;
endpackage

// File: rtl/spdma_req_gen.sv
// Module: request generator for one DMA direction.
// Drives a single request when at least one item or slot is available and a
// burst request when at least BURST items or slots are available. Both are
// gated by the direction enable. Assumes avail_i never exceeds DEPTH.
module spdma_req_gen #(
    parameter int DEPTH = 8,
    parameter int BURST = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [CW-1:0] avail_i,
    output logic          single_o,
    output logic          burst_o
);
    localparam logic [CW-1:0] BURST_C = CW'(BURST);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    // Purpose: combinational request decode from availability and enable
    always_comb begin
        single_o = en_i && (avail_i >= ONE_C);
        burst_o  = en_i && (avail_i >= BURST_C);
    end

    // Requests are never raised on a disabled direction
    assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (!single_o && !burst_o))
        else $error("request active while direction disabled");

    // A burst request always comes with a single request (R2/R4 thresholds nest)
    assert_burst_implies_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        burst_o |-> single_o)
        else $error("burst request without single request");
endmodule

// File: rtl/spdma_status.sv
// Module: raw interrupt status flags.
// Holds the transmit-finished, receive-finished and end-of-transmission bits.
// A completion pulse takes priority over a clear in the same cycle. The
// transmit-finished bit clears only while the transmit enable is low. Assumes
// tx_free_i never exceeds DEPTH.
module spdma_status #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tx_en_i,
    input  logic                     tx_done_i,
    input  logic                     rx_done_i,
    input  logic                     clr_tx_i,
    input  logic                     clr_rx_i,
    input  logic [CW-1:0]            tx_free_i,
    input  logic                     busy_i,
    output logic [spdma_pkg::ST_W-1:0] raw_o
);
    import spdma_pkg::*;

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic tx_done_q;
    logic rx_done_q;
    logic eot_q;

    // Purpose: transmit-finished flag with guarded clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_done_q <= 1'b0;
        else if (tx_done_i)
            tx_done_q <= 1'b1;
        else if (clr_tx_i && !tx_en_i)
            tx_done_q <= 1'b0;
    end

    // Purpose: receive-finished flag with unconditional clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_done_q <= 1'b0;
        else if (rx_done_i)
            rx_done_q <= 1'b1;
        else if (clr_rx_i)
            rx_done_q <= 1'b0;
    end

    // Purpose: end of transmission = transmit FIFO empty and shifter idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            eot_q <= 1'b0;
        else
            eot_q <= (tx_free_i == DEPTH_C) && !busy_i;
    end

    // Purpose: pack the flags into the status vector
    always_comb begin
        raw_o            = '0;
        raw_o[ST_TXDONE] = tx_done_q;
        raw_o[ST_RXDONE] = rx_done_q;
        raw_o[ST_EOT]    = eot_q;
    end

    assert_txdone_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_i |=> raw_o[ST_TXDONE])
        else $error("transmit done pulse not captured");

    assert_txclr_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_o[ST_TXDONE] && tx_en_i) |=> raw_o[ST_TXDONE])
        else $error("transmit done cleared while enable set");

    assert_rxdone_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_i |=> raw_o[ST_RXDONE])
        else $error("receive done pulse not captured");

    assert_eot_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_free_i == DEPTH_C) && !busy_i) |=> raw_o[ST_EOT])
        else $error("end of transmission not flagged");

    assert_eot_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !raw_o[ST_EOT])
        else $error("end of transmission flagged while shifter busy");
endmodule

// File: rtl/spdma_regs.sv
// Module: register file and bus decode.
// Holds the enables and the interrupt mask. Turns writes to the clear
// register into one-cycle clear pulses and muxes read data. Assumes
// DATA_W >= 3 and one-cycle write strobes.
module spdma_regs #(
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [spdma_pkg::ADDR_W-1:0]      addr_i,
    input  logic                              we_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    input  logic [spdma_pkg::ST_W-1:0]        raw_i,
    output logic                              rx_en_o,
    output logic                              tx_en_o,
    output logic                              clr_tx_o,
    output logic                              clr_rx_o,
    output logic [DATA_W-1:0]                 rdata_o,
    output logic                              irq_o
);
    import spdma_pkg::*;

    logic [CTL_W-1:0] ctrl_q;
    logic [ST_W-1:0]  mask_q;
    logic [ST_W-1:0]  masked;
    logic             wr_ctrl;
    logic             wr_mask;
    logic             wr_clr;

    // Purpose: write strobe decode
    always_comb begin
        wr_ctrl = we_i && (addr_i == REG_CTRL);
        wr_mask = we_i && (addr_i == REG_MASK);
        wr_clr  = we_i && (addr_i == REG_CLR);
    end

    // Purpose: control register with the two direction enables
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= wdata_i[CTL_W-1:0];
    end

    // Purpose: interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_mask)
            mask_q <= wdata_i[ST_W-1:0];
    end

    // Purpose: clear pulses, enables and masked status
    always_comb begin
        clr_tx_o = wr_clr && wdata_i[ST_TXDONE];
        clr_rx_o = wr_clr && wdata_i[ST_RXDONE];
        rx_en_o  = ctrl_q[CTL_RXEN];
        tx_en_o  = ctrl_q[CTL_TXEN];
        masked   = raw_i & mask_q;
        irq_o    = |masked;
    end

    // Purpose: read data mux, unused bits and write-only registers read zero
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_CTRL: rdata_o[CTL_W-1:0] = ctrl_q;
            REG_RAW:  rdata_o[ST_W-1:0]  = raw_i;
            REG_MASK: rdata_o[ST_W-1:0]  = mask_q;
            REG_MSKD: rdata_o[ST_W-1:0]  = masked;
            default:  rdata_o            = '0;
        endcase
    end

    assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((raw_i & mask_q) != '0))
        else $error("interrupt without a masked status bit");

    assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q))
        else $error("control register changed without a write");
endmodule

// File: rtl/spdma_ctrl.sv
// Module: top of the serial port DMA request controller.
// Connects the register file, the status flags and one request generator
// per direction. Assumes the FIFO level inputs are in the range 0..FIFO_DEPTH.
module spdma_ctrl #(
    parameter int FIFO_DEPTH = 8,
    parameter int BURST_LVL  = 4,
    parameter int DATA_W     = 32,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [spdma_pkg::ADDR_W-1:0] bus_addr,
    input  logic                         bus_we,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [CW-1:0]                rx_level,
    input  logic [CW-1:0]                tx_free,
    input  logic                         shifter_busy,
    input  logic                         tx_dma_done,
    input  logic                         rx_dma_done,
    output logic                         rx_req_single,
    output logic                         rx_req_burst,
    output logic                         tx_req_single,
    output logic                         tx_req_burst,
    output logic                         irq
);
    import spdma_pkg::*;

    logic            rx_en;
    logic            tx_en;
    logic            clr_tx;
    logic            clr_rx;
    logic [ST_W-1:0] raw;

    spdma_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr),
        .we_i     (bus_we),
        .wdata_i  (bus_wdata),
        .raw_i    (raw),
        .rx_en_o  (rx_en),
        .tx_en_o  (tx_en),
        .clr_tx_o (clr_tx),
        .clr_rx_o (clr_rx),
        .rdata_o  (bus_rdata),
        .irq_o    (irq)
    );

    spdma_status #(.DEPTH(FIFO_DEPTH)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en_i   (tx_en),
        .tx_done_i (tx_dma_done),
        .rx_done_i (rx_dma_done),
        .clr_tx_i  (clr_tx),
        .clr_rx_i  (clr_rx),
        .tx_free_i (tx_free),
        .busy_i    (shifter_busy),
        .raw_o     (raw)
    );

    spdma_req_gen #(.DEPTH(FIFO_DEPTH), .BURST(BURST_LVL)) u_rx_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (rx_en),
        .avail_i  (rx_level),
        .single_o (rx_req_single),
        .burst_o  (rx_req_burst)
    );

    spdma_req_gen #(.DEPTH(FIFO_DEPTH), .BURST(BURST_LVL)) u_tx_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (tx_en),
        .avail_i  (tx_free),
        .single_o (tx_req_single),
        .burst_o  (tx_req_burst)
    );

    // Receive clear with rx enable set still clears on the next edge
    assert_rxclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rx && !rx_dma_done) |=> !raw[ST_RXDONE])
        else $error("receive done not cleared");
endmodule

// File: tb/tb_spdma_ctrl.sv
// Directed bench for spdma_ctrl: one task per scenario, each checking itself.
module tb_spdma_ctrl;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [CW-1:0] rx_level = '0;
    logic [CW-1:0] tx_free = '0;
    logic          shifter_busy = 1'b1;
    logic          tx_dma_done = 1'b0;
    logic          rx_dma_done = 1'b0;
    logic          rx_req_single, rx_req_burst, tx_req_single, tx_req_burst, irq;

    int n_checks = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    spdma_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_level(rx_level),
        .tx_free(tx_free), .shifter_busy(shifter_busy), .tx_dma_done(tx_dma_done),
        .rx_dma_done(rx_dma_done), .rx_req_single(rx_req_single),
        .rx_req_burst(rx_req_burst), .tx_req_single(tx_req_single),
        .tx_req_burst(tx_req_burst), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic reqs(output logic [3:0] r);
        #1;
        r = {tx_req_burst, tx_req_single, rx_req_burst, rx_req_single};
    endtask

    // R11: state while reset is held
    task automatic t_reset();
        logic [31:0] d;
        logic [3:0] r;
        rx_level = 4'd8; tx_free = 4'd8; shifter_busy = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd0, d); chk("R11", "ctrl in reset", d, 0);
        rd(3'd1, d); chk("R11", "raw in reset", d, 0);
        rd(3'd2, d); chk("R11", "mask in reset", d, 0);
        reqs(r);     chk("R11", "requests in reset", {28'd0, r}, 0);
        chk("R11", "irq in reset", {31'd0, irq}, 0);
        shifter_busy = 1'b1; tx_free = 4'd0; rx_level = 4'd0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    // R5: gating with enables clear, then readback
    task automatic t_gating();
        logic [31:0] d;
        logic [3:0] r;
        rx_level = 4'd8; tx_free = 4'd8;
        reqs(r); chk("R5", "requests with enables clear", {28'd0, r}, 0);
        wr(3'd0, 32'h2);
        rd(3'd0, d); chk("R5", "ctrl readback tx only", d, 2);
        reqs(r); chk("R5", "rx gated, tx live", {28'd0, r}, 32'hC);
        wr(3'd0, 32'h0);
        reqs(r); chk("R5", "all gated again", {28'd0, r}, 0);
        rx_level = 0; tx_free = 0;
    endtask

    // R1 R2: receive thresholds
    task automatic t_rx();
        logic [3:0] r;
        wr(3'd0, 32'h1);
        for (int lvl = 0; lvl <= DEPTH; lvl++) begin
            rx_level = CW'(lvl);
            reqs(r);
            chk("R1", $sformatf("rx single at %0d", lvl), {31'd0, r[0]}, {31'd0, lvl >= 1});
            chk("R2", $sformatf("rx burst at %0d", lvl),  {31'd0, r[1]}, {31'd0, lvl >= 4});
        end
        rx_level = 0;
        wr(3'd0, 32'h0);
    endtask

    // R3 R4: transmit thresholds
    task automatic t_tx();
        logic [3:0] r;
        wr(3'd0, 32'h2);
        for (int f = 0; f <= DEPTH; f++) begin
            tx_free = CW'(f);
            reqs(r);
            chk("R3", $sformatf("tx single at %0d", f), {31'd0, r[2]}, {31'd0, f >= 1});
            chk("R4", $sformatf("tx burst at %0d", f),  {31'd0, r[3]}, {31'd0, f >= 4});
        end
        tx_free = 0;
        wr(3'd0, 32'h0);
    endtask

    // R6 R7: transmit completion and guarded clear
    task automatic t_txdone();
        logic [31:0] d;
        logic [3:0] r;
        shifter_busy = 1'b1; tx_free = 4'd5;
        wr(3'd0, 32'h2);
        @(negedge clk); tx_dma_done = 1'b1;
        @(negedge clk); tx_dma_done = 1'b0;
        rd(3'd1, d); chk("R6", "tx done set", d & 1, 1);
        wr(3'd4, 32'h1);
        rd(3'd1, d); chk("R7", "clear ignored while enabled", d & 1, 1);
        wr(3'd0, 32'h0);
        reqs(r); chk("R5", "tx requests off after disable", {30'd0, r[3:2]}, 0);
        wr(3'd4, 32'h1);
        rd(3'd1, d); chk("R7", "clear after disable", d & 1, 0);
        wr(3'd0, 32'h2);
        reqs(r); chk("R5", "tx requests resume", {30'd0, r[3:2]}, 3);
        wr(3'd0, 32'h0);
        tx_free = 0;
    endtask

    // R8: receive completion cleared with enable still set
    task automatic t_rxdone();
        logic [31:0] d;
        wr(3'd0, 32'h1);
        @(negedge clk); rx_dma_done = 1'b1;
        @(negedge clk); rx_dma_done = 1'b0;
        rd(3'd1, d); chk("R8", "rx done set", (d >> 1) & 1, 1);
        wr(3'd4, 32'h2);
        rd(3'd1, d); chk("R8", "rx done cleared with enable set", (d >> 1) & 1, 0);
        wr(3'd0, 32'h0);
    endtask

    // R12: set wins over a same-cycle clear
    task automatic t_prio();
        logic [31:0] d;
        @(negedge clk);
        bus_addr = 3'd4; bus_wdata = 32'h3; bus_we = 1'b1;
        tx_dma_done = 1'b1; rx_dma_done = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tx_dma_done = 1'b0; rx_dma_done = 1'b0;
        rd(3'd1, d); chk("R12", "set beats clear", d & 3, 3);
        wr(3'd4, 32'h3);
        rd(3'd1, d); chk("R12", "later clear works", d & 3, 0);
    endtask

    // R9: end of transmission
    task automatic t_eot();
        logic [31:0] d;
        tx_free = 4'd8; shifter_busy = 1'b1;
        @(negedge clk);
        rd(3'd1, d); chk("R9", "busy shifter blocks eot", (d >> 2) & 1, 0);
        shifter_busy = 1'b0;
        @(negedge clk);
        rd(3'd1, d); chk("R9", "eot set when empty and idle", (d >> 2) & 1, 1);
        wr(3'd4, 32'h7);
        rd(3'd1, d); chk("R9", "eot unaffected by clear", (d >> 2) & 1, 1);
        tx_free = 4'd7;
        @(negedge clk);
        rd(3'd1, d); chk("R9", "eot drops with data queued", (d >> 2) & 1, 0);
    endtask

    // R10: mask, masked status and irq
    task automatic t_irq();
        logic [31:0] d;
        tx_free = 4'd8; shifter_busy = 1'b0;
        @(negedge clk);
        chk("R10", "irq low with zero mask", {31'd0, irq}, 0);
        wr(3'd2, 32'h3);
        rd(3'd2, d); chk("R10", "mask readback", d, 3);
        rd(3'd3, d); chk("R10", "masked hides eot", d, 0);
        chk("R10", "irq low when masked off", {31'd0, irq}, 0);
        wr(3'd2, 32'h4);
        rd(3'd3, d); chk("R10", "masked shows eot", d, 4);
        chk("R10", "irq high", {31'd0, irq}, 1);
        wr(3'd2, 32'h0);
        chk("R10", "irq low after unmask", {31'd0, irq}, 0);
    endtask

    initial begin
        t_reset();
        t_gating();
        t_rx();
        t_tx();
        t_txdone();
        t_rxdone();
        t_prio();
        t_eot();
        t_irq();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule